// File: doc/BRIEF.md
# Predictive Current Cost Datapath

This block scores one candidate switching vector of a three-phase active rectifier bridge. From the sampled phase currents, phase voltages, DC-link voltage and per-phase current references, it predicts the phase currents at the next sample. It then returns the sum of the squared differences between each reference and its prediction. A search controller outside this block presents each candidate in turn and keeps the one with the smallest cost.

All arithmetic is signed fixed point with WL bits in total, FL of which are fractional. The computation is time-multiplexed over a fixed schedule of 11 control steps on two Booth multipliers and two ripple-carry adders. Three scratch registers and a cost accumulator hold the intermediate results. Multiplying by a switch bit or by two is done by gating and shifting, not by a multiplier. The two model constants are parameters in the same Q format: the current decay factor (KL_Q) and the sample-time-over-inductance factor (TSL_Q).

Top module: `pred_cost_core`

## Requirements
- R1: While rst_n is low, and afterwards until the first result, done is 0 and cost is 0.
- R2: A start sampled high while the block is idle latches all data inputs. done is then high for exactly one cycle, 11 clock edges after the accepting edge. A start that is high in the cycle where done is high is accepted.
- R3: With sat() clamping to [-2^(WL-1), 2^(WL-1)-1] and q(a,b) = sat(floor(a·b / 2^FL)), the cost is computed as follows. vt = q(vdc, T3), where T3 = floor((2^FL+1)/3). For each phase m in the order u, v, w: d = sat(v_m + k_m·vt); h = sat(ref_m − q(KL_Q, i_m)); e = sat(h − q(TSL_Q, d)); acc = sat(acc + q(e, e)). acc starts at 0 and the final acc is the cost.
- R4: The switch encoding is sw_vec[0] = phase u, sw_vec[1] = phase v and sw_vec[2] = phase w, where 1 means the upper device conducts. The coupling factor is k_m = S_a + S_b − 2·S_m, with a and b the two other phases.
- R5: Every product, sum and difference saturates to the WL-bit range instead of wrapping. For example, a very large positive error yields cost = 2^(WL-1) − 1.
- R6: A start raised while a computation is running is ignored. The running result uses the inputs latched at its own start, and done pulses only once.
- R7: cost changes only together with done and is otherwise held, whatever the data inputs do.
- R8: The vectors 000 and 111 produce the same cost, because they apply no coupling voltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (ignored while busy) |
| sw_vec | input | 3 | Candidate switch vector, bit0 = u, bit1 = v, bit2 = w |
| i_u | input | WL | Measured phase-u current |
| i_v | input | WL | Measured phase-v current |
| i_w | input | WL | Measured phase-w current |
| v_u | input | WL | Phase-u voltage |
| v_v | input | WL | Phase-v voltage |
| v_w | input | WL | Phase-w voltage |
| vdc | input | WL | DC-link voltage |
| ref_u | input | WL | Phase-u current reference |
| ref_v | input | WL | Phase-v current reference |
| ref_w | input | WL | Phase-w current reference |
| cost | output | WL | Tracking cost of the last finished candidate |
| done | output | 1 | One-cycle result strobe |

## Verification
All-zero inputs check that the accumulator clears and that the result is zero. Sweeping all eight switch vectors over one operating point separates the coupling gate settings for k = −2, −1, 0, +1 and +2. Comparing 000 with 111 confirms that both null vectors cancel.

An extreme error drives the saturation paths. A second start during a run, and a start in the done cycle, tell an ignored request apart from a back-to-back one. A quiet period with changing data shows that the result is held. Many random operating points exercise the rounding of each rescaled product against the bench's own integer model.

// File: rtl/pred_cost_pkg.sv
package pred_cost_pkg;

    localparam int N_PHASE = 3;
    localparam int N_STEPS = 1 + 3 * N_PHASE + 1;

    typedef enum logic [1:0] {
        SUB_PREP = 2'd0,
        SUB_ERR  = 2'd1,
        SUB_SQ   = 2'd2
    } sub_e;

    // coupling factor k_m = S_a + S_b - 2*S_m, range -2..+2
    function automatic logic signed [2:0] coupling_k(logic [2:0] s, int m);
        int a;
        int b;
        a = (m + 1) % N_PHASE;
        b = (m + 2) % N_PHASE;
        return 3'(int'(s[a]) + int'(s[b]) - 2 * int'(s[m]));
    endfunction

endpackage

// File: rtl/fxp_booth_mul.sv
module fxp_booth_mul #(
    parameter int WL = 24,
    parameter int FL = 13
) (
    input  logic [WL-1:0] a,
    input  logic [WL-1:0] b,
    output logic [WL-1:0] y
);
    localparam int PW = 2 * WL;
    localparam longint LMAX = (longint'(1) <<< (WL - 1)) - 1;
    localparam logic signed [PW-1:0] PMAX = PW'(LMAX);
    localparam logic signed [PW-1:0] PMIN = -PMAX - 1;

    logic signed [PW-1:0] ae;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic [WL:0]          bx;

    assign ae = PW'($signed(a));
    assign bx = {b, 1'b0};

    // radix-2 Booth recoding, one partial product per multiplier bit
    always_comb begin
        prod = '0;
        for (int i = 0; i < WL; i++) begin
            case (bx[i+1 -: 2])
                2'b01:   prod = prod + (ae <<< i);
                2'b10:   prod = prod - (ae <<< i);
                default: prod = prod;
            endcase
        end
    end

    assign scaled = prod >>> FL;

    always_comb begin
        if (scaled > PMAX)      y = PMAX[WL-1:0];
        else if (scaled < PMIN) y = PMIN[WL-1:0];
        else                    y = scaled[WL-1:0];
    end
endmodule

// File: rtl/fxp_rca_add.sv
module fxp_rca_add #(
    parameter int WL = 24
) (
    input  logic [WL:0]   a,
    input  logic [WL:0]   b,
    input  logic          sub,
    output logic [WL-1:0] y
);
    localparam int SW = WL + 2;
    localparam longint LMAX = (longint'(1) <<< (WL - 1)) - 1;
    localparam logic signed [SW-1:0] SMAX = SW'(LMAX);
    localparam logic signed [SW-1:0] SMIN = -SMAX - 1;

    logic [SW-1:0] xa;
    logic [SW-1:0] xb;
    logic [SW-1:0] s;
    logic [SW-1:0] c;

    assign xa   = {a[WL], a};
    assign xb   = {b[WL], b} ^ {SW{sub}};
    assign c[0] = sub;

    for (genvar g = 0; g < SW; g++) begin : g_fa
        assign s[g] = xa[g] ^ xb[g] ^ c[g];
        if (g < SW - 1) begin : g_cy
            assign c[g+1] = (xa[g] & xb[g]) | (c[g] & (xa[g] ^ xb[g]));
        end
    end

    always_comb begin
        if ($signed(s) > SMAX)      y = SMAX[WL-1:0];
        else if ($signed(s) < SMIN) y = SMIN[WL-1:0];
        else                        y = s[WL-1:0];
    end
endmodule

// File: rtl/pred_seq.sv
module pred_seq #(
    parameter int STEPS = 11,
    localparam int STW = $clog2(STEPS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           run,
    output logic [STW-1:0] step,
    output logic           accept,
    output logic           last
);
    typedef struct packed {
        logic           run;
        logic [STW-1:0] step;
    } seq_t;

    seq_t q, d;

    assign run    = q.run;
    assign step   = q.step;
    assign accept = start & ~q.run;
    assign last   = q.run && (int'(q.step) == STEPS - 1);

    always_comb begin
        d = q;
        if (accept) begin
            d.run  = 1'b1;
            d.step = '0;
        end else if (q.run) begin
            if (last) begin
                d.run  = 1'b0;
                d.step = '0;
            end else begin
                d.step = q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pred_cost_core.sv
module pred_cost_core
    import pred_cost_pkg::*;
#(
    parameter int WL    = 24,
    parameter int FL    = 13,
    parameter int KL_Q  = 8183,
    parameter int TSL_Q = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    sw_vec,
    input  logic [WL-1:0] i_u,
    input  logic [WL-1:0] i_v,
    input  logic [WL-1:0] i_w,
    input  logic [WL-1:0] v_u,
    input  logic [WL-1:0] v_v,
    input  logic [WL-1:0] v_w,
    input  logic [WL-1:0] vdc,
    input  logic [WL-1:0] ref_u,
    input  logic [WL-1:0] ref_v,
    input  logic [WL-1:0] ref_w,
    output logic [WL-1:0] cost,
    output logic          done
);
    localparam int STW = $clog2(N_STEPS);
    localparam logic [WL-1:0] KL_C    = WL'(KL_Q);
    localparam logic [WL-1:0] TSL_C   = WL'(TSL_Q);
    localparam logic [WL-1:0] THIRD_C = WL'(((2 ** FL) + 1) / 3);

    typedef struct packed {
        logic [N_PHASE-1:0][WL-1:0] cur;
        logic [N_PHASE-1:0][WL-1:0] volt;
        logic [N_PHASE-1:0][WL-1:0] refc;
        logic [WL-1:0]              vdc;
        logic [2:0]                 sw;
        logic [WL-1:0]              r1;
        logic [WL-1:0]              r2;
        logic [WL-1:0]              r3;
        logic [WL-1:0]              acc;
        logic [WL-1:0]              cost;
        logic                       done;
    } dp_t;

    dp_t q, n;

    logic           run;
    logic [STW-1:0] step;
    logic           accept;
    logic           last;

    logic [WL-1:0] m1_a, m1_b, m1_y, m2_a, m2_b, m2_y;
    logic [WL:0]   a1_a, a1_b, a2_a, a2_b;
    logic          a1_sub, a2_sub;
    logic [WL-1:0] a1_y, a2_y;

    int               ph;
    sub_e             sp;
    logic signed [2:0] kv;

    function automatic logic [WL:0] ext(logic [WL-1:0] x);
        return {x[WL-1], x};
    endfunction

    pred_seq #(.STEPS(N_STEPS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .run(run), .step(step), .accept(accept), .last(last)
    );

    fxp_booth_mul #(.WL(WL), .FL(FL)) u_mul1 (.a(m1_a), .b(m1_b), .y(m1_y));
    fxp_booth_mul #(.WL(WL), .FL(FL)) u_mul2 (.a(m2_a), .b(m2_b), .y(m2_y));
    fxp_rca_add   #(.WL(WL))          u_add1 (.a(a1_a), .b(a1_b), .sub(a1_sub), .y(a1_y));
    fxp_rca_add   #(.WL(WL))          u_add2 (.a(a2_a), .b(a2_b), .sub(a2_sub), .y(a2_y));

    // step decode and operand steering
    always_comb begin
        int s_i;
        s_i = int'(step);
        ph  = 0;
        sp  = SUB_PREP;
        if (s_i >= 1 && s_i <= 3 * N_PHASE) begin
            ph = (s_i - 1) / 3;
            sp = sub_e'(2'((s_i - 1) % 3));
        end
        kv = coupling_k(q.sw, ph);

        m1_a = '0; m1_b = '0; m2_a = '0; m2_b = '0;
        a1_a = '0; a1_b = '0; a1_sub = 1'b0;
        a2_a = '0; a2_b = '0; a2_sub = 1'b0;

        if (s_i == 0) begin
            m1_a = q.vdc;
            m1_b = THIRD_C;
        end else if (s_i <= 3 * N_PHASE) begin
            case (sp)
                SUB_PREP: begin
                    m1_a   = KL_C;
                    m1_b   = q.cur[ph];
                    a1_a   = ext(q.volt[ph]);
                    // gating: |k| * vt by select and shift, sign via subtract
                    if (kv == 3'sd2 || kv == -3'sd2) a1_b = {q.r1, 1'b0};
                    else if (kv != 3'sd0)            a1_b = ext(q.r1);
                    else                             a1_b = '0;
                    a1_sub = kv[2];
                    a2_a   = ext(q.refc[ph]);
                    a2_b   = ext(m1_y);
                    a2_sub = 1'b1;
                end
                SUB_ERR: begin
                    m1_a   = TSL_C;
                    m1_b   = q.r3;
                    a1_a   = ext(q.r2);
                    a1_b   = ext(m1_y);
                    a1_sub = 1'b1;
                end
                SUB_SQ: begin
                    m2_a   = q.r2;
                    m2_b   = q.r2;
                    a2_a   = ext(q.acc);
                    a2_b   = ext(m2_y);
                    a2_sub = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        n      = q;
        n.done = 1'b0;
        if (accept) begin
            n.cur  = {i_w, i_v, i_u};
            n.volt = {v_w, v_v, v_u};
            n.refc = {ref_w, ref_v, ref_u};
            n.vdc  = vdc;
            n.sw   = sw_vec;
            n.acc  = '0;
        end
        if (run) begin
            if (int'(step) == 0) begin
                n.r1 = m1_y;
            end else if (last) begin
                n.cost = q.acc;
                n.done = 1'b1;
            end else begin
                case (sp)
                    SUB_PREP: begin
                        n.r3 = a1_y;
                        n.r2 = a2_y;
                    end
                    SUB_ERR: n.r2  = a1_y;
                    SUB_SQ:  n.acc = a2_y;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign cost = q.cost;
    assign done = q.done;
endmodule

// File: rtl/pred_cost_chk.sv
module pred_cost_chk #(
    parameter int WL = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          run,
    input logic          done,
    input logic [WL-1:0] cost
);
    logic       trk;
    logic [4:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk <= 1'b0;
            cyc <= '0;
        end else if (start && !run) begin
            trk <= 1'b1;
            cyc <= '0;
        end else if (trk && cyc != 5'd31) begin
            cyc <= cyc + 5'd1;
        end
    end

    // R2: strobe lasts one cycle
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2 / R6: strobe only 11 edges after the accepted start
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (trk && cyc == 5'd11));

    // R7: result held outside the strobe
    p_cost_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(cost));

    // R3: a sum of squares is never negative
    p_cost_nonneg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cost[WL-1]);
endmodule

bind pred_cost_core pred_cost_chk #(.WL(WL)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .run(run), .done(done), .cost(cost)
);

// File: tb/tb_pred_cost_core.sv
module tb_pred_cost_core;
    localparam int CLK_PERIOD = 10;
    localparam int WL = 24;
    localparam int FL = 13;
    localparam int KL_Q = 8183;
    localparam int TSL_Q = 22;
    localparam longint T3 = ((longint'(1) <<< FL) + 1) / 3;
    localparam longint MAXV = (longint'(1) <<< (WL - 1)) - 1;
    localparam longint MINV = -MAXV - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] sw_vec = '0;
    logic signed [WL-1:0] i_u = '0, i_v = '0, i_w = '0;
    logic signed [WL-1:0] v_u = '0, v_v = '0, v_w = '0;
    logic signed [WL-1:0] vdc = '0;
    logic signed [WL-1:0] ref_u = '0, ref_v = '0, ref_w = '0;
    logic [WL-1:0] cost;
    logic done;

    int checks = 0;
    int errors = 0;
    int dcount = 0;
    string tag = "R1";

    pred_cost_core #(.WL(WL), .FL(FL), .KL_Q(KL_Q), .TSL_Q(TSL_Q)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sw_vec(sw_vec),
        .i_u(i_u), .i_v(i_v), .i_w(i_w),
        .v_u(v_u), .v_v(v_v), .v_w(v_w), .vdc(vdc),
        .ref_u(ref_u), .ref_v(ref_v), .ref_w(ref_w),
        .cost(cost), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic longint sat(longint x);
        if (x > MAXV) return MAXV;
        if (x < MINV) return MINV;
        return x;
    endfunction

    function automatic longint mulq(longint a, longint b);
        longint p;
        p = a * b;
        return sat(p >>> FL);
    endfunction

    function automatic longint model_cost();
        longint ii [3];
        longint vv [3];
        longint rr [3];
        longint vt, acc, d, h, e;
        int k;
        ii[0] = longint'(i_u);   ii[1] = longint'(i_v);   ii[2] = longint'(i_w);
        vv[0] = longint'(v_u);   vv[1] = longint'(v_v);   vv[2] = longint'(v_w);
        rr[0] = longint'(ref_u); rr[1] = longint'(ref_v); rr[2] = longint'(ref_w);
        vt  = mulq(longint'(vdc), T3);
        acc = 0;
        for (int m = 0; m < 3; m++) begin
            k   = int'(sw_vec[(m + 1) % 3]) + int'(sw_vec[(m + 2) % 3]) - 2 * int'(sw_vec[m]);
            d   = sat(vv[m] + longint'(k) * vt);
            h   = sat(rr[m] - mulq(KL_Q, ii[m]));
            e   = sat(h - mulq(TSL_Q, d));
            acc = sat(acc + mulq(e, e));
        end
        return acc;
    endfunction

    // behavioural reference: busy flag, edge counter, pending result
    bit     m_busy = 0;
    int     m_cnt = 0;
    longint m_pend = 0;
    longint m_cost = 0;
    bit     m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_cost = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 11) begin
                    m_busy = 0;
                    m_cost = m_pend;
                    m_done = 1;
                end
            end else if (start) begin
                m_busy = 1;
                m_cnt  = 0;
                m_pend = model_cost();
            end
        end
    end

    task automatic check(string t, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        check((tag == "R1") ? "R1" : "R2", longint'(done), longint'(m_done));
        check(tag, longint'(cost), m_cost);
        if (done) dcount++;
    end

    task automatic set_in(int iu, int iv, int iw, int vu, int vv, int vw,
                          int vd, int ru, int rv, int rw, logic [2:0] s);
        i_u = WL'(iu); i_v = WL'(iv); i_w = WL'(iw);
        v_u = WL'(vu); v_v = WL'(vv); v_w = WL'(vw);
        vdc = WL'(vd);
        ref_u = WL'(ru); ref_v = WL'(rv); ref_w = WL'(rw);
        sw_vec = s;
    endtask

    task automatic launch(int iu, int iv, int iw, int vu, int vv, int vw,
                          int vd, int ru, int rv, int rw, logic [2:0] s);
        @(negedge clk);
        set_in(iu, iv, iw, vu, vv, vw, vd, ru, rv, rw, s);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    function automatic int rnd(int span);
        return int'($urandom % (2 * span + 1)) - span;
    endfunction

    initial begin
        repeat (500000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        longint c0, c7;
        int d0;
        tag = "R1";
        repeat (3) @(negedge clk);
        check("R1", longint'(cost), 0);
        check("R1", longint'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        tag = "R3";
        launch(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b000);
        settle();
        check("R3", longint'(cost), 0);
        launch(8192, -4096, -4096, 200000, -100000, -100000, 450000, 9000, -4000, -5000, 3'b001);
        settle();
        launch(-30000, 12000, 18000, -50000, 150000, -100000, 400000, -20000, 30000, -10000, 3'b110);
        settle();

        tag = "R4";
        for (int s = 0; s < 8; s++) begin
            launch(4000, -1000, -3000, 120000, -60000, -60000, 450000, 6000, -2000, -4000, 3'(s));
            settle();
            if (s == 0) c0 = longint'(cost);
            if (s == 7) c7 = longint'(cost);
        end
        tag = "R8";
        check("R8", c7, c0);

        tag = "R5";
        launch(-(1 << 23), 0, 0, 0, 0, 0, 0, (1 << 23) - 1, 0, 0, 3'b000);
        settle();
        check("R5", longint'(cost), MAXV);
        launch((1 << 23) - 1, (1 << 23) - 1, 0, (1 << 23) - 1, -(1 << 23), 0,
               (1 << 23) - 1, -(1 << 23), (1 << 23) - 1, 0, 3'b011);
        settle();

        tag = "R6";
        d0 = dcount;
        launch(2000, -1000, -1000, 90000, -45000, -45000, 450000, 3000, -1500, -1500, 3'b100);
        repeat (3) @(negedge clk);
        set_in(-9000, 9000, 0, -200000, 200000, 0, 100000, 9000, -9000, 0, 3'b010);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check("R6", longint'(dcount - d0), 1);

        tag = "R2";
        launch(1000, 2000, -3000, 10000, 20000, -30000, 300000, 500, 600, -1100, 3'b101);
        repeat (10) @(negedge clk);
        launch(-7000, 3000, 4000, -80000, 30000, 50000, 350000, -6000, 2000, 4000, 3'b011);
        settle();

        tag = "R7";
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            set_in(rnd(60000), rnd(60000), rnd(60000), rnd(300000), rnd(300000),
                   rnd(300000), rnd(500000), rnd(60000), rnd(60000), rnd(60000), 3'($urandom));
        end

        tag = "R3";
        for (int n = 0; n < 150; n++) begin
            launch(rnd(65536), rnd(65536), rnd(65536), rnd(300000), rnd(300000),
                   rnd(300000), rnd(524288), rnd(65536), rnd(65536), rnd(65536), 3'($urandom));
            settle();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule